// File: doc/BRIEF.md
# Timed Parallel Bit-Bang Port

This block turns a group of general-purpose lines into a byte-wide parallel port that software drives through two streams. Bytes arriving on an output stream are put onto the lines one per timer interval, and the pin state comes back on a sample stream. A reloadable interval timer, clocked from the system clock and loaded from a divisor input, sets the pace of every access. A per-line direction mask decides which lines are driven; the others are left floating so that external logic can drive them.

Every time the port puts a new byte on the lines it pulls an active-low write strobe, and every time it captures the lines it pulls an active-low read strobe, so that external logic can be clocked by the port's own accesses. Two sampling policies exist. In free-running mode the lines are captured on every timer interval whether or not anything was written. In lock-step mode a capture happens only when a byte is written, and it is taken in the same cycle as the write is accepted, before the new value reaches the lines, so each returned sample answers exactly one written byte.

Top module: `bitBangPort`

## Requirements
- R1: After reset, `pinOut` is 0, `wrStrobeN` and `rdStrobeN` are 1, `sampleValid` is 0 and `pinOe` equals `dirMask`.
- R2: The timer produces one tick every `tickDivisor`+1 clock cycles; `outReady` is 1 only in tick cycles, so at most one byte is taken per tick.
- R3: In the cycle after a byte is taken, `pinOut` shows that byte (masked by `dirMask`) and `wrStrobeN` is 0; with no further byte it stays 0 for exactly `tickDivisor`+1 cycles.
- R4: A capture makes `sampleValid` 1 for exactly one cycle in the following cycle, with `sampleData` equal to `pinIn` in the tick cycle, and drives `rdStrobeN` to 0 for one timer interval.
- R5: With `syncMode` = 0, a capture happens on every tick, whether or not a byte is written.
- R6: With `syncMode` = 1, a capture happens only on ticks where a byte is taken, and it returns the line state from before that byte is applied.
- R7: When no byte is offered at a tick, `pinOut` keeps its last value and `wrStrobeN` is not pulled low.
- R8: A line whose `dirMask` bit is 0 (1 = output) has `pinOe` 0 and `pinOut` 0; the corresponding bit of a written byte is discarded and does not appear if the line is later turned into an output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickDivisor | input | 16 | Timer reload; interval is this value plus one cycles |
| syncMode | input | 1 | 1 = capture only with writes, 0 = capture every tick |
| dirMask | input | 8 | Per-line direction, 1 = output |
| outValid | input | 1 | Output stream byte available |
| outData | input | 8 | Output stream byte |
| outReady | output | 1 | Byte taken this cycle when outValid is also 1 |
| pinIn | input | 8 | Line state seen at the pads |
| pinOut | output | 8 | Value driven onto output lines |
| pinOe | output | 8 | Per-line output enable |
| wrStrobeN | output | 1 | Active-low write strobe |
| rdStrobeN | output | 1 | Active-low read strobe |
| sampleValid | output | 1 | One-cycle pulse with a new sample |
| sampleData | output | 8 | Captured line state |

## Verification
The embedded properties watch, on every cycle, that the counter restarts after each tick, that the strobes and the held output value only move on ticks, that each accepted byte or capture is followed by its strobe and sample pulse, and that lock-step mode never captures without a write. The exact strobe widths, the interval length for a given divisor, the masking of input lines across a direction change, and the lock-step rule that a sample shows the lines before the new byte can only be shown by the directed scenarios, which compare port values against counts worked out from the requirements.

// File: rtl/bitBangPkg.sv
package bitBangPkg;
  // Per-cycle commands from control to datapath
  typedef struct packed {
    logic tick;    // timer interval boundary
    logic load;    // apply a new output byte
    logic sample;  // capture the lines
  } bbCmd_t;
endpackage

// File: rtl/bbTimer.sv
module bbTimer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] divisor,
  output logic             tick
);
  logic [CNT_W-1:0] cnt;

  // >= rather than == so a lowered divisor never strands the counter
  assign tick = (cnt >= divisor);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  assert_tick_restart_R2: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> (cnt == '0));
endmodule

// File: rtl/bbCtrl.sv
module bbCtrl
  import bitBangPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] tickDivisor,
  input  logic             syncMode,
  input  logic             outValid,
  output logic             outReady,
  output bbCmd_t           cmd
);
  logic tick;

  bbTimer #(.CNT_W(CNT_W)) i_timer (
    .clk     (clk),
    .rstN    (rstN),
    .divisor (tickDivisor),
    .tick    (tick)
  );

  always_comb begin
    outReady   = tick;
    cmd.tick   = tick;
    cmd.load   = tick && outValid;
    cmd.sample = tick && (syncMode ? outValid : 1'b1);
  end

  assert_sync_sample_needs_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    (syncMode && cmd.sample) |-> cmd.load);
  assert_async_every_tick_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!syncMode && tick) |-> cmd.sample);
endmodule

// File: rtl/bbDatapath.sv
module bbDatapath
  import bitBangPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  bbCmd_t            cmd,
  input  logic [DATA_W-1:0] dirMask,
  input  logic [DATA_W-1:0] outData,
  input  logic [DATA_W-1:0] pinIn,
  output logic [DATA_W-1:0] pinOut,
  output logic [DATA_W-1:0] pinOe,
  output logic              wrStrobeN,
  output logic              rdStrobeN,
  output logic              sampleValid,
  output logic [DATA_W-1:0] sampleData
);
  logic [DATA_W-1:0] pinReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinReg      <= '0;
      wrStrobeN   <= 1'b1;
      rdStrobeN   <= 1'b1;
      sampleValid <= 1'b0;
      sampleData  <= '0;
    end else begin
      sampleValid <= cmd.sample;
      if (cmd.load)   pinReg     <= outData & dirMask;
      if (cmd.sample) sampleData <= pinIn;
      if (cmd.tick) begin
        wrStrobeN <= !cmd.load;
        rdStrobeN <= !cmd.sample;
      end
    end
  end

  assign pinOe  = dirMask;
  assign pinOut = pinReg & dirMask;

  assert_hold_without_load_R7: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.load |=> $stable(pinReg));
  assert_wr_moves_on_tick_R3: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.tick |=> $stable(wrStrobeN));
  assert_rd_moves_on_tick_R4: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.tick |=> $stable(rdStrobeN));
  assert_load_strobes_R3: assert property (@(posedge clk) disable iff (!rstN)
    cmd.load |=> !wrStrobeN);
  assert_sample_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    cmd.sample |=> (!rdStrobeN && sampleValid));
endmodule

// File: rtl/bitBangPort.sv
module bitBangPort
  import bitBangPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  tickDivisor,
  input  logic              syncMode,
  input  logic [DATA_W-1:0] dirMask,
  input  logic              outValid,
  input  logic [DATA_W-1:0] outData,
  output logic              outReady,
  input  logic [DATA_W-1:0] pinIn,
  output logic [DATA_W-1:0] pinOut,
  output logic [DATA_W-1:0] pinOe,
  output logic              wrStrobeN,
  output logic              rdStrobeN,
  output logic              sampleValid,
  output logic [DATA_W-1:0] sampleData
);
  bbCmd_t cmd;

  bbCtrl #(.CNT_W(CNT_W)) i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .tickDivisor (tickDivisor),
    .syncMode    (syncMode),
    .outValid    (outValid),
    .outReady    (outReady),
    .cmd         (cmd)
  );

  bbDatapath #(.DATA_W(DATA_W)) i_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .cmd         (cmd),
    .dirMask     (dirMask),
    .outData     (outData),
    .pinIn       (pinIn),
    .pinOut      (pinOut),
    .pinOe       (pinOe),
    .wrStrobeN   (wrStrobeN),
    .rdStrobeN   (rdStrobeN),
    .sampleValid (sampleValid),
    .sampleData  (sampleData)
  );

  assert_sample_one_cycle_R4: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && !outReady) |=> !sampleValid);
endmodule

// File: tb/test_bitBangPort.sv
module test_bitBangPort;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] tickDivisor = 16'd3;
  logic        syncMode = 1'b0;
  logic [7:0]  dirMask = 8'hFF;
  logic        outValid = 1'b0;
  logic [7:0]  outData = 8'h00;
  logic        outReady;
  logic [7:0]  pinDrive = 8'h00;
  logic        loopback = 1'b0;
  logic [7:0]  pinIn;
  logic [7:0]  pinOut, pinOe, sampleData;
  logic        wrStrobeN, rdStrobeN, sampleValid;
  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;
  assign pinIn = loopback ? pinOut : pinDrive;

  bitBangPort i_bitBangPort (
    .clk(clk), .rstN(rstN), .tickDivisor(tickDivisor), .syncMode(syncMode),
    .dirMask(dirMask), .outValid(outValid), .outData(outData), .outReady(outReady),
    .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe), .wrStrobeN(wrStrobeN),
    .rdStrobeN(rdStrobeN), .sampleValid(sampleValid), .sampleData(sampleData)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic waitTick();
    while (!outReady) @(negedge clk);
  endtask

  // Offer one byte; return at the negedge just after it was taken
  task automatic sendByte(input logic [7:0] b);
    outValid = 1'b1;
    outData  = b;
    waitTick();
    @(negedge clk);
    outValid = 1'b0;
  endtask

  task automatic countLow(output int n, input bit useWr);
    n = 0;
    while ((useWr ? wrStrobeN : rdStrobeN) == 1'b0 && n < 100) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic testReset();
    check("R1", "pinOut", pinOut, 0);
    check("R1", "wrStrobeN", wrStrobeN, 1);
    check("R1", "rdStrobeN", rdStrobeN, 1);
    check("R1", "sampleValid", sampleValid, 0);
    check("R1", "pinOe", pinOe, 8'hFF);
  endtask

  task automatic testTimer(input int div);
    int gap;
    tickDivisor = 16'(div);
    @(negedge clk); @(negedge clk);
    waitTick();
    @(negedge clk);
    gap = 1;
    while (!outReady && gap < 100) begin
      gap++;
      @(negedge clk);
    end
    check("R2", "tick interval", gap, div + 1);
  endtask

  task automatic testWrite();
    int n;
    syncMode = 1'b1;
    tickDivisor = 16'd3;
    sendByte(8'h5A);
    check("R3", "pinOut after write", pinOut, 8'h5A);
    check("R3", "wrStrobeN low", wrStrobeN, 0);
    countLow(n, 1'b1);
    check("R3", "write strobe width", n, 4);
  endtask

  task automatic testHold();
    int strobes = 0;
    int changes = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (!wrStrobeN) strobes++;
      if (pinOut != 8'h5A) changes++;
    end
    check("R7", "write strobes with empty stream", strobes, 0);
    check("R7", "pinOut changes with empty stream", changes, 0);
  endtask

  task automatic testAsync();
    int samples = 0;
    syncMode = 1'b0;
    pinDrive = 8'hA5;
    waitTick();
    @(negedge clk);
    check("R4", "sampleValid", sampleValid, 1);
    check("R4", "sampleData", sampleData, 8'hA5);
    check("R4", "rdStrobeN", rdStrobeN, 0);
    @(negedge clk);
    check("R4", "sampleValid one cycle", sampleValid, 0);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (sampleValid) samples++;
    end
    check("R5", "samples in 16 cycles without writes", samples, 4);
  endtask

  task automatic testSync();
    int samples = 0;
    int n;
    syncMode = 1'b1;
    for (int i = 0; i < 8; i++) @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (sampleValid || !rdStrobeN) samples++;
    end
    check("R6", "captures without writes", samples, 0);
    sendByte(8'h11);
    for (int i = 0; i < 8; i++) @(negedge clk);
    loopback = 1'b1;
    sendByte(8'h22);
    check("R6", "sample shows previous byte", sampleData, 8'h11);
    check("R6", "sampleValid with write", sampleValid, 1);
    check("R6", "pinOut new byte", pinOut, 8'h22);
    countLow(n, 1'b0);
    check("R4", "read strobe width", n, 4);
    loopback = 1'b0;
  endtask

  task automatic testMask();
    dirMask = 8'h0F;
    @(negedge clk);
    check("R8", "pinOe follows mask", pinOe, 8'h0F);
    sendByte(8'hFF);
    check("R8", "input lines not driven", pinOut, 8'h0F);
    for (int i = 0; i < 6; i++) @(negedge clk);
    dirMask = 8'hFF;
    @(negedge clk);
    check("R8", "discarded bits stay discarded", pinOut, 8'h0F);
    check("R8", "pinOe all outputs", pinOe, 8'hFF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testTimer(3);
    testTimer(0);
    testTimer(6);
    testWrite();
    testHold();
    testAsync();
    testSync();
    testMask();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule